// File: doc/BRIEF.md
# Processor condition code register

This block holds the eight-bit flag register of a small accumulator CPU. Each executed instruction hands it an operation class and two operands. A small add/subtract/logic unit inside the block forms the result, and the register then takes new overflow, half-carry, negative, zero and carry flags from it. The same register carries the maskable-interrupt mask. The mask gates incoming interrupt requests, is raised when an interrupt is entered, and is restored from the saved byte when the handler returns.

The sequencer drives the side inputs:
- a strobe marking the end of register stacking on interrupt entry;
- a return strobe together with the unstacked byte;
- explicit set-mask and clear-mask commands;
- a direct write of the arithmetic flags.

The packed byte on `ccrOut` is what gets stacked. In the strobe cycle of interrupt entry it still shows the old mask.

Top module: `ccr_unit`

## Requirements
- R1: The layout of `ccrOut` is fixed: bit 7 overflow V, bit 4 half-carry H, bit 3 mask I, bit 2 negative N, bit 1 zero Z, bit 0 carry C. Bits 6 and 5 read 1 at all times, whatever is written or unstacked.
- R2: While `rstN` is low and after its release, `ccrOut` is 8'h68: I is 1 and all other flags are 0.
- R3: V is set on two's-complement overflow of add, add-with-carry and subtract, and cleared otherwise. AND, OR, XOR and move clear V.
- R4: H takes the carry from bit 3 into bit 4 only for add and add-with-carry. Subtract, logic and move leave H unchanged.
- R5: For every class, N takes bit 7 of the result and Z is set when the 8-bit result is zero. The `opClass` codes are 0 add, 1 add-with-carry, 2 subtract (opA−opB), 3 AND, 4 OR, 5 XOR and 6 move (result = opB). `aluResult` shows the result combinationally.
- R6: C is the carry-out for add and add-with-carry, and add-with-carry uses the current C as its carry-in. C is the borrow (opA < opB unsigned) for subtract. Logic and move leave C unchanged.
- R7: `irqEnable` is the inverse of I, and `irqAccept` is `irqReq` gated by `irqEnable`. Both are combinational.
- R8: In the cycle that `intEntry` is high, `ccrOut` still shows the old I. From the next cycle on, I is 1.
- R9: `rti` loads the whole register from `stackedCcr`, including I. It overrides every other input in the same cycle.
- R10: `setMask` or `intEntry` sets I, and `clrMask` clears it. Setting wins when both arrive together. Apart from `rti`, nothing else clears I.
- R11: `ccrWrite` loads V, H, N, Z and C from `ccrWrData`, leaves I unchanged, and takes precedence over an instruction in the same cycle.
- R12: Flags change one clock after the qualifying input. With `execValid` low and no strobes, the register holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| execValid | input | 1 | An instruction completes this cycle |
| opClass | input | 3 | Operation class code |
| opA | input | 8 | First ALU operand (accumulator) |
| opB | input | 8 | Second ALU operand |
| intEntry | input | 1 | Stacking of an interrupt entry has finished |
| rti | input | 1 | Return from interrupt: load stackedCcr |
| stackedCcr | input | 8 | Byte pulled from the stack |
| setMask | input | 1 | Set-mask command |
| clrMask | input | 1 | Clear-mask command |
| ccrWrite | input | 1 | Direct write of the arithmetic flags |
| ccrWrData | input | 8 | Data for the direct write |
| irqReq | input | 1 | A maskable interrupt is pending |
| aluResult | output | 8 | Result of the internal ALU |
| ccrOut | output | 8 | Packed condition code byte |
| irqEnable | output | 1 | Maskable interrupts are enabled |
| irqAccept | output | 1 | The pending request is passed on |

## Verification
`aluResult`, `irqEnable` and `irqAccept` are combinational. The bench checks them 1 ns after inputs are driven on a falling edge, in the same cycle. Every flag in `ccrOut` has one register in its path, so the expected byte is queued when the inputs are driven and compared 1 ns after the following rising edge. The interrupt-entry check reads `ccrOut` in the strobe cycle itself, to see the old mask, and then through the queue one cycle later.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int CCR_W = 8;
  localparam int BIT_C = 0;
  localparam int BIT_Z = 1;
  localparam int BIT_N = 2;
  localparam int BIT_I = 3;
  localparam int BIT_H = 4;
  localparam int BIT_V = 7;
  localparam logic [CCR_W-1:0] FIXED_ONES = 8'h60;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_ADC = 3'd1,
    OP_SUB = 3'd2,
    OP_AND = 3'd3,
    OP_OR  = 3'd4,
    OP_EOR = 3'd5,
    OP_MOV = 3'd6
  } opClassE;

  typedef struct packed {
    logic loadAll;
    logic loadFlags;
    logic updV;
    logic updHalf;
    logic updNZ;
    logic updCarry;
    logic setI;
    logic clrI;
  } ccrStrobeT;
endpackage

// File: rtl/ccr_alu.sv
module ccr_alu
  import ccr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  opClassE           op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              carryIn,
  output logic [DATA_W-1:0] result,
  output logic              carryOut,
  output logic              halfCarry,
  output logic              overflow
);
  localparam int HB = DATA_W / 2;
  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0] wide;
  logic [HB:0]     half;
  logic            cin;

  assign cin = (op == OP_ADC) ? carryIn : 1'b0;

  always_comb begin
    wide      = '0;
    half      = '0;
    result    = '0;
    carryOut  = 1'b0;
    halfCarry = 1'b0;
    overflow  = 1'b0;
    case (op)
      OP_ADD, OP_ADC: begin
        wide      = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
        half      = {1'b0, a[HB-1:0]} + {1'b0, b[HB-1:0]} + {{HB{1'b0}}, cin};
        result    = wide[DATA_W-1:0];
        carryOut  = wide[DATA_W];
        halfCarry = half[HB];
        overflow  = (a[MSB] & b[MSB] & ~result[MSB]) |
                    (~a[MSB] & ~b[MSB] & result[MSB]);
      end
      OP_SUB: begin
        wide     = {1'b0, a} - {1'b0, b};
        result   = wide[DATA_W-1:0];
        carryOut = wide[DATA_W];
        overflow = (a[MSB] & ~b[MSB] & ~result[MSB]) |
                   (~a[MSB] & b[MSB] & result[MSB]);
      end
      OP_AND:  result = a & b;
      OP_OR:   result = a | b;
      OP_EOR:  result = a ^ b;
      default: result = b;
    endcase
  end
endmodule

// File: rtl/ccr_ctrl.sv
module ccr_ctrl
  import ccr_pkg::*;
(
  input  logic      execValid,
  input  opClassE   op,
  input  logic      intEntry,
  input  logic      rti,
  input  logic      setMask,
  input  logic      clrMask,
  input  logic      ccrWrite,
  input  logic      maskNow,
  input  logic      irqReq,
  output ccrStrobeT strobe,
  output logic      irqEnable,
  output logic      irqAccept
);
  logic execGo;
  logic isAdd;
  logic isArith;
  logic raiseI;

  assign isAdd   = (op == OP_ADD) || (op == OP_ADC);
  assign isArith = isAdd || (op == OP_SUB);
  assign execGo  = execValid & ~rti & ~ccrWrite;
  assign raiseI  = intEntry | setMask;

  always_comb begin
    strobe           = '0;
    strobe.loadAll   = rti;
    strobe.loadFlags = ccrWrite & ~rti;
    strobe.updV      = execGo;
    strobe.updHalf   = execGo & isAdd;
    strobe.updNZ     = execGo;
    strobe.updCarry  = execGo & isArith;
    strobe.setI      = ~rti & raiseI;
    strobe.clrI      = ~rti & ~raiseI & clrMask;
  end

  assign irqEnable = ~maskNow;
  assign irqAccept = irqReq & ~maskNow;
endmodule

// File: rtl/ccr_datapath.sv
module ccr_datapath
  import ccr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ccrStrobeT         strobe,
  input  logic [DATA_W-1:0] result,
  input  logic              carryOut,
  input  logic              halfCarry,
  input  logic              overflow,
  input  logic [CCR_W-1:0]  stackedCcr,
  input  logic [CCR_W-1:0]  ccrWrData,
  output logic [CCR_W-1:0]  ccrOut,
  output logic              carryNow,
  output logic              maskNow
);
  logic vFlag, hFlag, iMask, nFlag, zFlag, cFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vFlag <= 1'b0;
      hFlag <= 1'b0;
      iMask <= 1'b1;
      nFlag <= 1'b0;
      zFlag <= 1'b0;
      cFlag <= 1'b0;
    end else if (strobe.loadAll) begin
      vFlag <= stackedCcr[BIT_V];
      hFlag <= stackedCcr[BIT_H];
      iMask <= stackedCcr[BIT_I];
      nFlag <= stackedCcr[BIT_N];
      zFlag <= stackedCcr[BIT_Z];
      cFlag <= stackedCcr[BIT_C];
    end else begin
      if (strobe.loadFlags) begin
        vFlag <= ccrWrData[BIT_V];
        hFlag <= ccrWrData[BIT_H];
        nFlag <= ccrWrData[BIT_N];
        zFlag <= ccrWrData[BIT_Z];
        cFlag <= ccrWrData[BIT_C];
      end else begin
        if (strobe.updV)     vFlag <= overflow;
        if (strobe.updHalf)  hFlag <= halfCarry;
        if (strobe.updNZ) begin
          nFlag <= result[DATA_W-1];
          zFlag <= (result == '0);
        end
        if (strobe.updCarry) cFlag <= carryOut;
      end
      if (strobe.setI)      iMask <= 1'b1;
      else if (strobe.clrI) iMask <= 1'b0;
    end
  end

  always_comb begin
    ccrOut        = FIXED_ONES;
    ccrOut[BIT_V] = vFlag;
    ccrOut[BIT_H] = hFlag;
    ccrOut[BIT_I] = iMask;
    ccrOut[BIT_N] = nFlag;
    ccrOut[BIT_Z] = zFlag;
    ccrOut[BIT_C] = cFlag;
  end

  assign carryNow = cFlag;
  assign maskNow  = iMask;
endmodule

// File: rtl/ccr_unit.sv
module ccr_unit
  import ccr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              execValid,
  input  logic [2:0]        opClass,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              intEntry,
  input  logic              rti,
  input  logic [7:0]        stackedCcr,
  input  logic              setMask,
  input  logic              clrMask,
  input  logic              ccrWrite,
  input  logic [7:0]        ccrWrData,
  input  logic              irqReq,
  output logic [DATA_W-1:0] aluResult,
  output logic [7:0]        ccrOut,
  output logic              irqEnable,
  output logic              irqAccept
);
  opClassE   opE;
  ccrStrobeT strobe;
  logic      carryOut, halfCarry, overflow, carryNow, maskNow;

  assign opE = opClassE'(opClass);

  ccr_alu #(.DATA_W(DATA_W)) u_alu (
    .op(opE), .a(opA), .b(opB), .carryIn(carryNow),
    .result(aluResult), .carryOut(carryOut),
    .halfCarry(halfCarry), .overflow(overflow)
  );

  ccr_ctrl u_ctrl (
    .execValid(execValid), .op(opE), .intEntry(intEntry), .rti(rti),
    .setMask(setMask), .clrMask(clrMask), .ccrWrite(ccrWrite),
    .maskNow(maskNow), .irqReq(irqReq), .strobe(strobe),
    .irqEnable(irqEnable), .irqAccept(irqAccept)
  );

  ccr_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .result(aluResult),
    .carryOut(carryOut), .halfCarry(halfCarry), .overflow(overflow),
    .stackedCcr(stackedCcr), .ccrWrData(ccrWrData), .ccrOut(ccrOut),
    .carryNow(carryNow), .maskNow(maskNow)
  );
endmodule

// File: rtl/ccr_unit_chk.sv
module ccr_unit_chk (
  input logic       clk,
  input logic       rstN,
  input logic       execValid,
  input logic [2:0] opClass,
  input logic [7:0] opB,
  input logic       intEntry,
  input logic       rti,
  input logic       setMask,
  input logic       clrMask,
  input logic       ccrWrite,
  input logic [7:0] ccrOut,
  input logic       irqAccept
);
  AST_FIXED_ONES: assert property (@(posedge clk) disable iff (!rstN)
    ccrOut[6:5] == 2'b11); // R1

  AST_RESET_MASK: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> ccrOut[3]); // R2

  AST_H_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (execValid && opClass > 3'd1 && !rti && !ccrWrite) |=> $stable(ccrOut[4])); // R4

  AST_MOVE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (execValid && opClass == 3'd6 && !rti && !ccrWrite) |=> (ccrOut[1] == ($past(opB) == 8'd0))); // R5

  AST_IRQ_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    ccrOut[3] |-> !irqAccept); // R7

  AST_MASK_ON_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (intEntry && !rti) |=> ccrOut[3]); // R8

  AST_MASK_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ccrOut[3] && !clrMask && !rti) |=> ccrOut[3]); // R10

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (setMask && clrMask && !rti) |=> ccrOut[3]); // R10
endmodule

bind ccr_unit ccr_unit_chk u_chk (
  .clk(clk), .rstN(rstN), .execValid(execValid), .opClass(opClass),
  .opB(opB), .intEntry(intEntry), .rti(rti), .setMask(setMask),
  .clrMask(clrMask), .ccrWrite(ccrWrite), .ccrOut(ccrOut),
  .irqAccept(irqAccept)
);

// File: tb/ccr_unit_bench.sv
`timescale 1ns/1ps
module ccr_unit_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       execValid = 1'b0;
  logic [2:0] opClass = '0;
  logic [7:0] opA = '0, opB = '0;
  logic       intEntry = 1'b0, rti = 1'b0, setMask = 1'b0, clrMask = 1'b0;
  logic       ccrWrite = 1'b0, irqReq = 1'b0;
  logic [7:0] stackedCcr = '0, ccrWrData = '0;
  logic [7:0] aluResult, ccrOut;
  logic       irqEnable, irqAccept;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } itemT;
  itemT sbq[$];
  logic [7:0] model;

  always #2 clk = ~clk;

  ccr_unit u_ccr_unit (
    .clk(clk), .rstN(rstN), .execValid(execValid), .opClass(opClass),
    .opA(opA), .opB(opB), .intEntry(intEntry), .rti(rti),
    .stackedCcr(stackedCcr), .setMask(setMask), .clrMask(clrMask),
    .ccrWrite(ccrWrite), .ccrWrData(ccrWrData), .irqReq(irqReq),
    .aluResult(aluResult), .ccrOut(ccrOut), .irqEnable(irqEnable),
    .irqAccept(irqAccept)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expRes(input logic [2:0] op, input logic [7:0] a,
                                        input logic [7:0] b, input logic cin);
    case (op)
      3'd0: return a + b;
      3'd1: return a + b + {7'd0, cin};
      3'd2: return a - b;
      3'd3: return a & b;
      3'd4: return a | b;
      3'd5: return a ^ b;
      default: return b;
    endcase
  endfunction

  function automatic logic [7:0] nextCcr(input logic [7:0] cur, input logic ex,
      input logic [2:0] op, input logic [7:0] a, input logic [7:0] b,
      input logic ie, input logic rt, input logic [7:0] stk, input logic sm,
      input logic cm, input logic wr, input logic [7:0] wd);
    logic [7:0] n;
    logic [7:0] res;
    int ur, sr, cin;
    n = cur;
    if (rt) return stk | 8'h60;
    if (wr) n = (wd & 8'h97) | (cur & 8'h08) | 8'h60;
    else if (ex) begin
      cin = (op == 3'd1) ? int'(cur[0]) : 0;
      res = expRes(op, a, b, cur[0]);
      if (op <= 3'd1) begin
        ur = int'(a) + int'(b) + cin;
        sr = int'($signed(a)) + int'($signed(b)) + cin;
        n[0] = (ur > 255);
        n[4] = ((int'(a) % 16) + (int'(b) % 16) + cin) > 15;
        n[7] = (sr > 127) || (sr < -128);
      end else if (op == 3'd2) begin
        sr = int'($signed(a)) - int'($signed(b));
        n[0] = (a < b);
        n[7] = (sr > 127) || (sr < -128);
      end else n[7] = 1'b0;
      n[2] = res[7];
      n[1] = (res == 8'd0);
    end
    if (ie || sm) n[3] = 1'b1;
    else if (cm) n[3] = 1'b0;
    return n;
  endfunction

  task automatic drive(input string tag, input logic ex, input logic [2:0] op,
      input logic [7:0] a, input logic [7:0] b, input logic ie, input logic rt,
      input logic [7:0] stk, input logic sm, input logic cm, input logic wr,
      input logic [7:0] wd);
    itemT it;
    @(negedge clk);
    execValid = ex; opClass = op; opA = a; opB = b; intEntry = ie; rti = rt;
    stackedCcr = stk; setMask = sm; clrMask = cm; ccrWrite = wr; ccrWrData = wd;
    #1;
    if (ex) check({tag, " R5 aluResult"}, aluResult, expRes(op, a, b, model[0]));
    it.exp = nextCcr(model, ex, op, a, b, ie, rt, stk, sm, cm, wr, wd);
    it.tag = tag;
    model = it.exp;
    sbq.push_back(it);
  endtask

  task automatic idle();
    drive("R12 hold", 1'b0, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00);
  endtask

  task automatic exec(input string tag, input logic [2:0] op, input logic [7:0] a, input logic [7:0] b);
    drive(tag, 1'b1, op, a, b, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00);
  endtask

  initial begin : monitor
    itemT it;
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        it = sbq.pop_front();
        check(it.tag, ccrOut, it.exp);
      end
    end
  end

  initial begin : watchdog
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    model = 8'h68;
    irqReq = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R2 reset value", ccrOut, 8'h68);
    check("R7 blocked in reset", {6'd0, irqEnable, irqAccept}, 8'h00);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    #1;
    check("R2 after release", ccrOut, 8'h68);

    drive("R10 clear mask", 1'b0, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00);
    idle();
    #1;
    check("R7 accept when unmasked", {6'd0, irqEnable, irqAccept}, 8'h03);

    exec("R3 R4 add signed overflow", 3'd0, 8'h7F, 8'h01);
    exec("R6 add carry out zero", 3'd0, 8'hFF, 8'h01);
    exec("R6 adc uses carry", 3'd1, 8'h00, 8'h00);
    exec("R6 sub borrow", 3'd2, 8'h00, 8'h01);
    exec("R4 sub keeps H", 3'd2, 8'h80, 8'h01);
    exec("R4 add sets H", 3'd0, 8'h08, 8'h08);
    exec("R4 R6 and keeps H and C", 3'd3, 8'hF0, 8'h0F);
    exec("R5 move zero", 3'd6, 8'h55, 8'h00);
    exec("R5 xor negative", 3'd5, 8'h0F, 8'hF0);
    idle();
    idle();

    drive("R11 write keeps I", 1'b1, 3'd0, 8'h7F, 8'h7F, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'hFF);
    drive("R1 write cannot clear fixed bits", 1'b0, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 8'h00);

    drive("R8 entry sets mask", 1'b0, 3'd0, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00);
    check("R8 old mask in entry cycle", {7'd0, ccrOut[3]}, 8'h00);
    idle();
    #1;
    check("R7 blocked after entry", {6'd0, irqEnable, irqAccept}, 8'h00);

    drive("R9 rti restores", 1'b1, 3'd0, 8'h01, 8'h01, 1'b0, 1'b1, 8'h95, 1'b1, 1'b0, 1'b1, 8'h00);
    drive("R1 R9 rti zero byte", 1'b0, 3'd0, 8'h00, 8'h00, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 8'h00);
    drive("R10 set beats clear", 1'b0, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0, 8'h00);
    drive("R10 entry beats clear", 1'b0, 3'd0, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00);
    drive("R10 clear alone", 1'b0, 3'd0, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 8'h00);
    idle();

    for (int k = 0; k < 400; k++) begin
      logic [31:0] r;
      r = $urandom;
      drive("R3 R6 random", r[0] | r[1], 3'($urandom % 7), 8'($urandom), 8'($urandom),
            (r[7:4] == 4'd0), (r[11:8] == 4'd0), 8'($urandom),
            (r[15:12] == 4'd0), (r[19:17] == 3'd0), (r[23:20] == 4'd0), 8'($urandom));
    end
    idle();
    idle();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule